// File: doc/BRIEF.md
# Programmable-Level Interrupt Priority Controller

This block gathers interrupt requests from twelve peripheral sources and decides which one, if any, the processor takes next. Each source's request counts only while that source's enable bit is set. Every source has a 2-bit priority level that software writes through a narrow register-write port. Among the pending sources, the block registers the winner's index and level and presents them on its request outputs.

The block also holds the processor-side interrupt state: a current level field and a global interrupt enable. The presented request is accepted only under four conditions: its level outranks the current level, the global enable is set, the request is valid, and an instruction-boundary strobe is high in the same cycle. On acceptance the block emits a one-cycle acknowledge that carries the source index and level, and it loads that level into the current level field.

Software clears the source flags itself; the block never clears a request. Software can write the current level field and the global enable through a status-write port.

Top module: `irq_level_ctrl`

## Requirements
- R1: After synchronous reset every source level is 3, the current level is 3, the global enable is 0, and `ack` and `req_valid` are 0.
- R2: A source is pending only when both its `src_flag` bit and its `src_en` bit are 1. A source that is not pending is never presented and never acknowledged.
- R3: When `cfg_we` is 1, the level of source `cfg_idx` is set to `cfg_lvl`. A write with `cfg_idx` of 12 or more changes no level.
- R4: One cycle after the inputs, `req_valid`, `req_idx` and `req_lvl` show the pending source with the numerically lowest level. Level 0 is the most urgent. Among equal levels, the lowest index wins. `req_valid` is 0 when nothing is pending.
- R5: A request is accepted only if `req_lvl` is strictly less than `cur_lvl`.
- R6: A request is accepted only while `gie` is 1.
- R7: A request is accepted only in a cycle where `instr_boundary` is 1.
- R8: On acceptance, `ack` is 1 for exactly one cycle, on the next clock edge. In that cycle `ack_idx` and `ack_lvl` hold the accepted source and its level, and `cur_lvl` equals `ack_lvl`.
- R9: When `ps_we` is 1, `cur_lvl` and `gie` load `ps_lvl` and `ps_gie` at the next edge.
- R10: If an acceptance and a status write occur in the same cycle, `cur_lvl` takes the accepted level and `gie` takes `ps_gie`.
- R11: An accepted request stays presented on `req_valid`/`req_idx` until its flag or enable is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_flag | input | 12 | Per-source interrupt flag |
| src_en | input | 12 | Per-source enable |
| cfg_we | input | 1 | Level write strobe |
| cfg_idx | input | 4 | Source whose level is written |
| cfg_lvl | input | 2 | Level value to write |
| ps_we | input | 1 | Status write strobe |
| ps_lvl | input | 2 | Current level value to write |
| ps_gie | input | 1 | Global enable value to write |
| instr_boundary | input | 1 | High when the current instruction completes |
| req_valid | output | 1 | A pending request is presented |
| req_idx | output | 4 | Index of the presented source |
| req_lvl | output | 2 | Level of the presented source |
| cur_lvl | output | 2 | Current processing level |
| gie | output | 1 | Global interrupt enable |
| ack | output | 1 | One-cycle acceptance pulse |
| ack_idx | output | 4 | Accepted source index |
| ack_lvl | output | 2 | Accepted level |

## Verification
Two actions can both target the current level field in one cycle: an interrupt acceptance and a software status write. The bench waits until a request is presented. It then asserts `instr_boundary` and `ps_we` together, and the status write carries a different level and a cleared enable. The bench checks for an acknowledge pulse, for the accepted level rather than the written one in `cur_lvl`, and for the written enable in `gie`. The strict level comparison is covered by sweeping all sixteen pairs of request level and current level, with the global enable both set and clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_LOWEST = '1;
endpackage

// File: rtl/irq_level_regs.sv
module irq_level_regs
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 12,
  parameter int unsigned IDX_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  lvl_t                        wr_lvl,
  output logic [N_SRC-1:0][LVL_W-1:0] levels
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_lvl
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    always_ff @(posedge clk) begin
      if (rst)
        levels[g] <= LVL_LOWEST;
      else if (wr_en && wr_idx == MY_IDX)
        levels[g] <= wr_lvl;
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_idx == MY_IDX) |=> $stable(levels[g])); // R3
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 12,
  parameter int unsigned IDX_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_SRC-1:0]            pending,
  input  logic [N_SRC-1:0][LVL_W-1:0] levels,
  output logic                        win_valid,
  output logic [IDX_W-1:0]            win_idx,
  output lvl_t                        win_lvl
);

  logic [IDX_W-1:0] best_idx;
  lvl_t             best_lvl;

  // Descending scan with <= leaves the lowest index among equal levels.
  always_comb begin
    best_idx = '0;
    best_lvl = LVL_LOWEST;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pending[i] && levels[i] <= best_lvl) begin
        best_idx = IDX_W'(i);
        best_lvl = levels[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid <= 1'b0;
      win_idx   <= '0;
      win_lvl   <= LVL_LOWEST;
    end else begin
      win_valid <= |pending;
      win_idx   <= best_idx;
      win_lvl   <= best_lvl;
    end
  end

  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> ((($past(pending) >> win_idx) & N_SRC'(1)) != '0)); // R2
  AST_IDLE_NO_PENDING: assert property (@(posedge clk) disable iff (rst)
    !win_valid |-> ($past(pending) == '0)); // R4
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (win_idx < IDX_W'(N_SRC))); // R4

endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  input  lvl_t             req_lvl,
  input  logic             boundary,
  input  logic             ps_we,
  input  lvl_t             ps_lvl,
  input  logic             ps_gie,
  output lvl_t             cur_lvl,
  output logic             gie,
  output logic             ack,
  output logic [IDX_W-1:0] ack_idx,
  output lvl_t             ack_lvl
);

  logic take;
  assign take = req_valid && gie && boundary && (req_lvl < cur_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_lvl <= LVL_LOWEST;
      gie     <= 1'b0;
      ack     <= 1'b0;
      ack_idx <= '0;
      ack_lvl <= LVL_LOWEST;
    end else begin
      ack <= take;
      if (take) begin
        ack_idx <= req_idx;
        ack_lvl <= req_lvl;
      end
      if (take)
        cur_lvl <= req_lvl;
      else if (ps_we)
        cur_lvl <= ps_lvl;
      if (ps_we)
        gie <= ps_gie;
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R8
  AST_ACK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ack |-> (cur_lvl == ack_lvl)); // R8
  AST_ACK_STRICT: assert property (@(posedge clk) disable iff (rst)
    ack |-> ($past(req_lvl) < $past(cur_lvl))); // R5
  AST_ACK_GIE: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(gie)); // R6
  AST_ACK_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(boundary)); // R7
  AST_PS_GIE: assert property (@(posedge clk) disable iff (rst)
    ps_we |=> (gie == $past(ps_gie))); // R9

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 12,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_flag,
  input  logic [N_SRC-1:0] src_en,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [LVL_W-1:0] cfg_lvl,
  input  logic             ps_we,
  input  logic [LVL_W-1:0] ps_lvl,
  input  logic             ps_gie,
  input  logic             instr_boundary,
  output logic             req_valid,
  output logic [IDX_W-1:0] req_idx,
  output logic [LVL_W-1:0] req_lvl,
  output logic [LVL_W-1:0] cur_lvl,
  output logic             gie,
  output logic             ack,
  output logic [IDX_W-1:0] ack_idx,
  output logic [LVL_W-1:0] ack_lvl
);

  logic [N_SRC-1:0]            pending;
  logic [N_SRC-1:0][LVL_W-1:0] levels;

  assign pending = src_flag & src_en;

  irq_level_regs #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_lvl(cfg_lvl), .levels(levels)
  );

  irq_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst(rst), .pending(pending), .levels(levels),
    .win_valid(req_valid), .win_idx(req_idx), .win_lvl(req_lvl)
  );

  irq_accept #(.IDX_W(IDX_W)) u_acc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
    .req_lvl(req_lvl), .boundary(instr_boundary), .ps_we(ps_we),
    .ps_lvl(ps_lvl), .ps_gie(ps_gie), .cur_lvl(cur_lvl), .gie(gie),
    .ack(ack), .ack_idx(ack_idx), .ack_lvl(ack_lvl)
  );

  AST_ACK_ENABLED_SRC: assert property (@(posedge clk) disable iff (rst)
    ack |-> ((($past(src_en, 2) >> ack_idx) & N_SRC'(1)) != '0)); // R2

endmodule

// File: tb/tb_irq_level_ctrl.sv
module tb_irq_level_ctrl;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_flag = '0, src_en = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [1:0] cfg_lvl = '0;
  logic ps_we = 1'b0;
  logic [1:0] ps_lvl = '0;
  logic ps_gie = 1'b0;
  logic instr_boundary = 1'b0;
  logic req_valid, gie, ack;
  logic [3:0] req_idx, ack_idx;
  logic [1:0] req_lvl, cur_lvl, ack_lvl;

  int checks = 0;
  int errors = 0;
  int lvl_m [N];

  always #5 clk = ~clk;

  irq_level_ctrl dut (
    .clk(clk), .rst(rst), .src_flag(src_flag), .src_en(src_en),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl),
    .ps_we(ps_we), .ps_lvl(ps_lvl), .ps_gie(ps_gie),
    .instr_boundary(instr_boundary), .req_valid(req_valid),
    .req_idx(req_idx), .req_lvl(req_lvl), .cur_lvl(cur_lvl), .gie(gie),
    .ack(ack), .ack_idx(ack_idx), .ack_lvl(ack_lvl)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_lvl(input int idx, input int l);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_lvl = 2'(l);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic write_ps(input int l, input bit g);
    ps_we = 1'b1; ps_lvl = 2'(l); ps_gie = g;
    tick();
    ps_we = 1'b0;
  endtask

  task automatic single_sweep(input string req);
    src_en = '1;
    for (int i = 0; i < N; i++) begin
      src_flag = N'(1) << i;
      tick();
      chk(req_valid && req_idx == 4'(i), req, int'(req_idx), i);
      chk(req_lvl == 2'(lvl_m[i]), req, int'(req_lvl), lvl_m[i]);
    end
    src_flag = '0;
    tick();
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] lfsr;
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk(cur_lvl == 2'd3, "R1 cur_lvl", int'(cur_lvl), 3);
    chk(gie == 1'b0, "R1 gie", int'(gie), 0);
    chk(ack == 1'b0, "R1 ack", int'(ack), 0);
    chk(req_valid == 1'b0, "R1 req_valid", int'(req_valid), 0);
    for (int i = 0; i < N; i++) lvl_m[i] = 3;
    single_sweep("R1 reset level");

    // R3/R4/R2 two level programs, patterned arbitration sweep
    lfsr = 24'h5A3C71;
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < N; i++) begin
        lvl_m[i] = (i * (pass == 0 ? 5 : 3) + pass + 2) % 4;
        write_lvl(i, lvl_m[i]);
      end
      single_sweep("R3 write");
      for (int k = 0; k < 400; k++) begin
        int bl, bi;
        logic [N-1:0] p;
        lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
        src_flag = lfsr[11:0];
        src_en = (k % 5 == 0) ? '1 : lfsr[23:12];
        p = src_flag & src_en;
        bl = 4; bi = 0;
        for (int i = 0; i < N; i++)
          if (p[i] && lvl_m[i] < bl) begin bl = lvl_m[i]; bi = i; end
        tick();
        if (p == '0) chk(!req_valid, "R2 none pending", int'(req_valid), 0);
        else begin
          chk(req_valid && req_idx == 4'(bi), "R4 winner idx", int'(req_idx), bi);
          chk(req_lvl == 2'(bl), "R4 winner lvl", int'(req_lvl), bl);
        end
      end
      src_flag = '0;
      tick();
    end
    // R3 out-of-range writes ignored
    for (int i = 12; i < 16; i++) write_lvl(i, 0);
    single_sweep("R3 out of range");

    // R2 disabled source never acknowledged
    write_ps(3, 1'b1);
    src_en = '0; src_flag = '1; instr_boundary = 1'b1;
    tick(); tick();
    chk(!req_valid && !ack, "R2 masked", int'(ack), 0);
    src_flag = '0; instr_boundary = 1'b0; src_en = '1;
    tick(); tick();

    // R5 R6 level/enable sweep on source 0
    for (int g = 0; g < 2; g++)
      for (int c = 0; c < 4; c++)
        for (int l = 0; l < 4; l++) begin
          bit exp_take;
          write_ps(c, g[0]);
          write_lvl(0, l);
          exp_take = (g == 1) && (l < c);
          src_flag = N'(1); instr_boundary = 1'b1;
          tick(); tick();
          chk(ack == exp_take, g ? "R5 strict level" : "R6 gie off", int'(ack), int'(exp_take));
          chk(cur_lvl == 2'(exp_take ? l : c), "R8 cur_lvl", int'(cur_lvl), exp_take ? l : c);
          src_flag = '0; instr_boundary = 1'b0;
          tick(); tick();
        end
    lvl_m[0] = 3;

    // R7 boundary needed, R8 pulse, R11 request kept
    write_lvl(5, 1);
    write_ps(3, 1'b1);
    src_flag = N'(1) << 5;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(!ack, "R7 no boundary", int'(ack), 0);
    end
    instr_boundary = 1'b1;
    tick();
    chk(ack && ack_idx == 4'd5, "R8 ack idx", int'(ack_idx), 5);
    chk(ack_lvl == 2'd1 && cur_lvl == 2'd1, "R8 ack lvl", int'(cur_lvl), 1);
    tick();
    chk(!ack, "R8 single pulse", int'(ack), 0);
    chk(req_valid && req_idx == 4'd5, "R11 still presented", int'(req_idx), 5);
    instr_boundary = 1'b0; src_flag = '0;
    tick();

    // R9 status write
    write_ps(2, 1'b0);
    chk(cur_lvl == 2'd2 && gie == 1'b0, "R9 status write", int'(cur_lvl), 2);

    // R10 acceptance and status write in one cycle
    write_ps(3, 1'b1);
    write_lvl(7, 2);
    src_flag = N'(1) << 7;
    tick();
    instr_boundary = 1'b1; ps_we = 1'b1; ps_lvl = 2'd0; ps_gie = 1'b0;
    tick();
    ps_we = 1'b0; instr_boundary = 1'b0;
    chk(ack && ack_idx == 4'd7, "R10 ack", int'(ack), 1);
    chk(cur_lvl == 2'd2, "R10 level from accept", int'(cur_lvl), 2);
    chk(gie == 1'b0, "R10 gie from write", int'(gie), 0);
    src_flag = '0;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule